// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a synchronous Moore state machine for a vending controller. It counts the credit from coins a sensor reports, in 5-cent units. The sensor raises one of three flags (5, 10 or 25 cents) for one cycle per coin. Anything else the sensor sees produces no flag.

When the credit reaches or passes 30 cents, the machine enters a selling state for one cycle and raises `sell_o`. It then clears the credit and returns to idle. No change is returned, so any excess above the threshold is kept. The credit is held inside the block and is not reported on any port.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_ni` is low, the credit is forced to zero and `sell_o` is low. After release, a full 30 cents is needed before the next sale.
- R2: A cycle with only `nickel_i` high adds 5 cents of credit. A cycle with only `dime_i` high adds 10 cents. A cycle with only `quarter_i` high adds 25 cents.
- R3: `sell_o` goes high in the cycle after the clock edge at which the credit reaches 30 cents or more. It stays high for exactly one cycle.
- R4: Overpayment is kept. After a sale the credit is zero whatever the excess was, so the next sale needs a full 30 cents again.
- R5: A cycle with no coin flag high leaves the credit unchanged.
- R6: A cycle with more than one coin flag high is treated as invalid and leaves the credit unchanged.
- R7: Coin flags that arrive during the selling cycle are ignored. The credit after that cycle is zero.
- R8: `sell_o` stays low whenever the credit is below 30 cents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| quarter_i | input | 1 | One-cycle pulse: a 25-cent coin was accepted |
| sell_o | output | 1 | High for one cycle when the credit reaches the threshold |

## Verification
The bench builds the block with its default parameters: a threshold of six 5-cent units, and coin values of one, two and five units. With these values the set of coin sequences that reach the threshold is small enough to cover completely.

The bench walks every ordering of coins, up to six deep, and stops each walk where it crosses the threshold. This covers exact hits, single-quarter overshoots and double-quarter overshoots. Idle gaps, multi-flag cycles and coins that arrive during a sale are mixed into these walks. A reset asserted part-way through a sequence is also tested.

// File: rtl/vend_pkg.sv
package vend_pkg;

  function automatic int unsigned vend_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned vend_bits(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  localparam int unsigned NUM_COINS = 3;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
#(
  parameter int unsigned NICKEL_UNITS  = 1,
  parameter int unsigned DIME_UNITS    = 2,
  parameter int unsigned QUARTER_UNITS = 5,
  parameter int unsigned SW            = 4
) (
  input  logic [NUM_COINS-1:0] flags_i,
  output logic                 valid_o,
  output logic [SW-1:0]        units_o
);

  localparam int unsigned VALS [NUM_COINS] = '{NICKEL_UNITS, DIME_UNITS, QUARTER_UNITS};

  logic [SW-1:0] masked [NUM_COINS];

  for (genvar g = 0; g < NUM_COINS; g++) begin : g_mask
    assign masked[g] = flags_i[g] ? SW'(VALS[g]) : '0;
  end

  // exactly one flag is a valid coin
  assign valid_o = (flags_i != '0) && ((flags_i & (flags_i - 1'b1)) == '0);

  always_comb begin
    units_o = '0;
    for (int i = 0; i < NUM_COINS; i++) units_o = units_o | masked[i];
  end

endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next #(
  parameter int unsigned THRESH_UNITS = 6,
  parameter int unsigned CW           = 3,
  parameter int unsigned SW           = 4
) (
  input  logic [CW-1:0] credit_i,
  input  logic          valid_i,
  input  logic [SW-1:0] units_i,
  output logic [CW-1:0] credit_o
);

  logic [SW-1:0] sum;
  logic          selling;

  assign selling = (credit_i == CW'(THRESH_UNITS));
  assign sum     = SW'(credit_i) + units_i;

  always_comb begin
    if (selling)                           credit_o = '0;
    else if (!valid_i)                     credit_o = credit_i;
    else if (sum >= SW'(THRESH_UNITS))     credit_o = CW'(THRESH_UNITS);
    else                                   credit_o = sum[CW-1:0];
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int unsigned THRESH_UNITS  = 6,
  parameter int unsigned NICKEL_UNITS  = 1,
  parameter int unsigned DIME_UNITS    = 2,
  parameter int unsigned QUARTER_UNITS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nickel_i,
  input  logic dime_i,
  input  logic quarter_i,
  output logic sell_o
);

  localparam int unsigned CW   = vend_bits(THRESH_UNITS);
  localparam int unsigned MAXV = vend_max3(NICKEL_UNITS, DIME_UNITS, QUARTER_UNITS);
  localparam int unsigned SW   = vend_bits(THRESH_UNITS + MAXV);

  logic [NUM_COINS-1:0] flags;
  logic                 coin_valid;
  logic [SW-1:0]        coin_units;
  logic [CW-1:0]        credit_q, credit_d;

  assign flags = {quarter_i, dime_i, nickel_i};

  vend_coin_decode #(
    .NICKEL_UNITS (NICKEL_UNITS),
    .DIME_UNITS   (DIME_UNITS),
    .QUARTER_UNITS(QUARTER_UNITS),
    .SW           (SW)
  ) u_decode (
    .flags_i(flags),
    .valid_o(coin_valid),
    .units_o(coin_units)
  );

  vend_credit_next #(
    .THRESH_UNITS(THRESH_UNITS),
    .CW          (CW),
    .SW          (SW)
  ) u_next (
    .credit_i(credit_q),
    .valid_i (coin_valid),
    .units_i (coin_units),
    .credit_o(credit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else         credit_q <= credit_d;
  end

  // Moore output: the selling state is credit == threshold
  assign sell_o = (credit_q == CW'(THRESH_UNITS));

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int unsigned THRESH_UNITS  = 6,
  parameter int unsigned QUARTER_UNITS = 5,
  parameter int unsigned CW            = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          nickel_i,
  input logic          dime_i,
  input logic          quarter_i,
  input logic          sell_o,
  input logic [CW-1:0] credit_q
);

  logic [2:0] fl;
  assign fl = {quarter_i, dime_i, nickel_i};

  p_sell_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sell_o |=> !sell_o);

  p_zero_after_sale_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sell_o |=> (credit_q == '0));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sell_o && fl == 3'b000) |=> $stable(credit_q));

  p_multi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sell_o && $countones(fl) > 1) |=> $stable(credit_q));

  p_quarter_add_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sell_o && fl == 3'b100 && (int'(credit_q) + QUARTER_UNITS < THRESH_UNITS))
    |=> (int'(credit_q) == int'($past(credit_q)) + QUARTER_UNITS));

  p_credit_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(credit_q) <= THRESH_UNITS);

endmodule

bind vend_ctrl vend_ctrl_chk #(
  .THRESH_UNITS (THRESH_UNITS),
  .QUARTER_UNITS(QUARTER_UNITS),
  .CW           (CW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .nickel_i (nickel_i),
  .dime_i   (dime_i),
  .quarter_i(quarter_i),
  .sell_o   (sell_o),
  .credit_q (credit_q)
);

// File: tb/vend_ctrl_tb.sv
`timescale 1ns/1ps
module vend_ctrl_tb;

  localparam int THR = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic nickel_i = 1'b0, dime_i = 1'b0, quarter_i = 1'b0;
  logic sell_o;

  int n_tests = 0;
  int n_fail  = 0;
  int mcredit = 0;

  always #2.5 clk = ~clk;

  vend_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .nickel_i(nickel_i), .dime_i(dime_i), .quarter_i(quarter_i),
    .sell_o(sell_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sell_o=%0b expected %0b (model credit %0d)", tag, act, exp, mcredit);
    end
  endtask

  // one clock with the given flags; model updated and output compared after the edge
  task automatic step(input logic n, input logic d, input logic q, input string tag);
    int cnt;
    int val;
    nickel_i = n; dime_i = d; quarter_i = q;
    @(posedge clk); #1;
    cnt = int'(n) + int'(d) + int'(q);
    val = n ? 1 : d ? 2 : 5;
    if (mcredit == THR)  mcredit = 0;
    else if (cnt == 1)   mcredit = (mcredit + val >= THR) ? THR : mcredit + val;
    check(tag, sell_o, mcredit == THR);
    nickel_i = 0; dime_i = 0; quarter_i = 0;
  endtask

  task automatic coin(input int c, input string tag);
    step(c == 0, c == 1, c == 2, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: output low during reset
    #7; check("R1", sell_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    step(0, 0, 0, "R5");

    // R2/R8: five nickels no sale, sixth sells
    for (int i = 0; i < 5; i++) coin(0, "R8");
    coin(0, "R2");
    step(0, 0, 0, "R4");

    // R1: reset mid-sequence clears credit
    coin(1, "R2"); coin(1, "R2");
    @(negedge clk); rst_ni = 1'b0; mcredit = 0; #1;
    check("R1", sell_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    coin(2, "R1");
    coin(0, "R1");   // exactly 30 after reset only if credit cleared
    step(0, 0, 0, "R4");

    // exhaustive coin orderings up to six deep
    for (int code = 0; code < 729; code++) begin
      int rem = code;
      for (int k = 0; k < 6 && mcredit != THR; k++) begin
        if (code % 4 == 0 && k == 1) step(0, 0, 0, "R5");
        if (code % 5 == 0 && k == 1) step(1, (code % 2) == 0, 1'b1, "R6");
        coin(rem % 3, (mcredit + 5 >= THR) ? "R3" : "R2");
        rem = rem / 3;
      end
      // sale cycle visible now; coin during it must be ignored
      if (code % 3 != 0) coin(code % 3, "R7");
      else               step(0, 0, 0, "R3");
      step(0, 0, 0, "R4");
    end

    // R4: after double-quarter overpayment, a dime alone does not sell
    coin(2, "R4"); coin(2, "R3"); step(0, 0, 0, "R4");
    coin(1, "R4"); step(0, 0, 0, "R4");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule